// File: doc/BRIEF.md
# Dual-Thread Shared Scheduler Queue

This block is one issue queue that sits in front of a single execution port and is shared by two hardware threads. Each thread has its own feeder queue upstream; every cycle the block may take at most one micro-op from one of the two feeders and store it in a free slot. A stored micro-op carries the owning thread number, two source-operand tags, each with a ready flag, and a destination tag.

Operands become ready when their tag shows up on a result-broadcast bus of up to `WAKE_N` tags per cycle. An entry whose two operands are ready may be dispatched, one per cycle, while the execution port reports itself available. Dispatch looks only at readiness and age and never at thread ownership. Fairness is applied at the input instead. Each thread may hold at most `DEPTH - SPARE` entries, so the other thread always finds room, and when both threads offer work they take turns. A per-thread flush removes every entry of one thread in a single cycle.

Top module: `dual_thread_sched_q`

## Requirements
- R1: After reset the queue is empty: `disp_valid` is 0, and `ins_take` is 0 while no feeder offers a micro-op.
- R2: At most one `ins_take` bit is set per cycle (bit t accepts the head of feeder t). When both threads are eligible in the same cycle, the one that did not insert most recently wins. After reset, thread 0 wins the first such contest.
- R3: When only one thread is eligible, its micro-op is accepted in that cycle, so a lone feeder inserts every cycle.
- R4: A thread already holding `DEPTH - SPARE` entries (6 with the defaults) is not accepted, even if slots are free.
- R5: No micro-op is accepted while all `DEPTH` slots are occupied.
- R6: While `exec_avail` is 0, `disp_valid` is 0 and no entry leaves the queue through dispatch.
- R7: When `exec_avail` is 1, the oldest stored entry (in insertion order) with both operands ready is dispatched, whatever thread owns it. An entry can be dispatched at the earliest in the cycle after its insertion.
- R8: A broadcast tag equal to a stored source tag makes that operand ready in the same cycle, so the entry may be dispatched in that cycle, and the operand stays ready afterwards. A micro-op inserted in a cycle where one of its source tags is broadcast stores that operand as ready.
- R9: While `flush` is 1, every entry of thread `flush_tid` (0 or 1) is removed at the next edge and is not dispatched in that cycle, and feeder `flush_tid` is not accepted in that cycle. Entries of the other thread are untouched.
- R10: A dispatch presents the owning thread on `disp_tid` and the entry's destination tag on `disp_dst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 2 | Bit t: feeder t offers a micro-op |
| ins_src_a | input | 2×TAG_W | First source tag, per feeder |
| ins_src_a_rdy | input | 2 | First source already ready, per feeder |
| ins_src_b | input | 2×TAG_W | Second source tag, per feeder |
| ins_src_b_rdy | input | 2 | Second source already ready, per feeder |
| ins_dst | input | 2×TAG_W | Destination tag, per feeder |
| ins_take | output | 2 | Bit t: head of feeder t accepted this cycle |
| wake_valid | input | WAKE_N | Broadcast lane valid |
| wake_tag | input | WAKE_N×TAG_W | Broadcast result tags |
| exec_avail | input | 1 | Execution port can accept a micro-op |
| flush | input | 1 | Remove all entries of one thread |
| flush_tid | input | 1 | Thread to flush |
| disp_valid | output | 1 | A micro-op is dispatched this cycle |
| disp_tid | output | 1 | Thread of the dispatched micro-op |
| disp_dst | output | TAG_W | Destination tag of the dispatched micro-op |

## Verification
The bench fills the queue with one thread only, with operands held not ready. A design with a wrong cap would accept a seventh entry, or stop early. It then starts the second feeder to reach a full queue, where an off-by-one in the full test would overwrite a live slot or lose one. Long mixed runs apply wakeups that match in the cycle of insertion or of dispatch, and flushes that collide with insertion and dispatch. These expose a design that misses a same-cycle tag match and leaves an entry stuck, that issues a younger ready entry ahead of an older one, that lets a flushed micro-op issue, or that lets one thread win every contested insertion cycle.

// File: rtl/dtsq_pkg.sv
package dtsq_pkg;
   localparam int unsigned THREADS   = 2;
   localparam int unsigned MIN_DEPTH = 8;
   localparam int unsigned MAX_DEPTH = 12;
   localparam int unsigned MAX_WAKE  = 2;

   typedef enum logic {
      THR_0 = 1'b0,
      THR_1 = 1'b1
   } thr_e;
endpackage

// File: rtl/dtsq_slot.sv
module dtsq_slot #(
   parameter int unsigned TAG_W  = 6,
   parameter int unsigned WAKE_N = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic                         wr_tid,
   input  logic [TAG_W-1:0]             wr_a,
   input  logic                         wr_a_rdy,
   input  logic [TAG_W-1:0]             wr_b,
   input  logic                         wr_b_rdy,
   input  logic [TAG_W-1:0]             wr_dst,
   input  logic [WAKE_N-1:0]            wk_v,
   input  logic [WAKE_N-1:0][TAG_W-1:0] wk_tag,
   input  logic                         kill,
   output logic                         vld,
   output logic                         tid,
   output logic [TAG_W-1:0]             dst,
   output logic                         ops_ready
);
   logic [TAG_W-1:0] tag_a, tag_b;
   logic             rdy_a, rdy_b;
   logic             hit_a, hit_b, hit_wa, hit_wb;

   // tag comparators against every broadcast lane, for stored and incoming tags
   always_comb begin
      hit_a  = 1'b0;
      hit_b  = 1'b0;
      hit_wa = 1'b0;
      hit_wb = 1'b0;
      for (int w = 0; w < int'(WAKE_N); w++) begin
         if (wk_v[w] && wk_tag[w] == tag_a)  hit_a  = 1'b1;
         if (wk_v[w] && wk_tag[w] == tag_b)  hit_b  = 1'b1;
         if (wk_v[w] && wk_tag[w] == wr_a)   hit_wa = 1'b1;
         if (wk_v[w] && wk_tag[w] == wr_b)   hit_wb = 1'b1;
      end
   end

   assign ops_ready = vld & (rdy_a | hit_a) & (rdy_b | hit_b);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld   <= 1'b0;
         tid   <= 1'b0;
         tag_a <= '0;
         tag_b <= '0;
         rdy_a <= 1'b0;
         rdy_b <= 1'b0;
         dst   <= '0;
      end else if (wr_en) begin
         vld   <= 1'b1;
         tid   <= wr_tid;
         tag_a <= wr_a;
         tag_b <= wr_b;
         rdy_a <= wr_a_rdy | hit_wa;
         rdy_b <= wr_b_rdy | hit_wb;
         dst   <= wr_dst;
      end else begin
         if (kill)  vld   <= 1'b0;
         if (hit_a) rdy_a <= 1'b1;
         if (hit_b) rdy_b <= 1'b1;
      end
   end
endmodule

// File: rtl/dtsq_age_pick.sv
module dtsq_age_pick #(
   parameter int unsigned DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DEPTH-1:0] vld,
   input  logic [DEPTH-1:0] alloc,
   input  logic [DEPTH-1:0] req,
   output logic [DEPTH-1:0] gnt
);
   // elder[i][j] set means slot i was written before slot j
   logic [DEPTH-1:0][DEPTH-1:0] elder;

   for (genvar i = 0; i < int'(DEPTH); i++) begin : g_row
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            elder[i] <= '0;
         end else if (alloc[i]) begin
            elder[i] <= '0;
         end else begin
            for (int j = 0; j < int'(DEPTH); j++)
               if (alloc[j]) elder[i][j] <= vld[i];
         end
      end

      logic blocked;
      always_comb begin
         blocked = 1'b0;
         for (int j = 0; j < int'(DEPTH); j++)
            if (req[j] && elder[j][i]) blocked = 1'b1;
      end
      assign gnt[i] = req[i] & ~blocked;
   end
endmodule

// File: rtl/dtsq_ins_arb.sv
module dtsq_ins_arb
   import dtsq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] want,
   output logic [1:0] take
);
   thr_e last;

   always_comb begin
      take = want;
      if (want == 2'b11) take = (last == THR_0) ? 2'b10 : 2'b01;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     last <= THR_1;
      else if (|take) last <= take[1] ? THR_1 : THR_0;
   end
endmodule

// File: rtl/dual_thread_sched_q.sv
module dual_thread_sched_q
   import dtsq_pkg::*;
#(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned TAG_W  = 6,
   parameter int unsigned WAKE_N = 2,
   parameter int unsigned SPARE  = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [1:0]                   ins_valid,
   input  logic [1:0][TAG_W-1:0]        ins_src_a,
   input  logic [1:0]                   ins_src_a_rdy,
   input  logic [1:0][TAG_W-1:0]        ins_src_b,
   input  logic [1:0]                   ins_src_b_rdy,
   input  logic [1:0][TAG_W-1:0]        ins_dst,
   output logic [1:0]                   ins_take,
   input  logic [WAKE_N-1:0]            wake_valid,
   input  logic [WAKE_N-1:0][TAG_W-1:0] wake_tag,
   input  logic                         exec_avail,
   input  logic                         flush,
   input  logic                         flush_tid,
   output logic                         disp_valid,
   output logic                         disp_tid,
   output logic [TAG_W-1:0]             disp_dst
);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam int unsigned CAP   = DEPTH - SPARE;
   localparam logic [CNT_W-1:0] CAP_V  = CNT_W'(CAP);
   localparam logic [CNT_W:0]   FULL_V = (CNT_W + 1)'(DEPTH);

   if (DEPTH < MIN_DEPTH || DEPTH > MAX_DEPTH) begin : g_bad_depth
      $error("dual_thread_sched_q: DEPTH out of range");
   end
   if (SPARE < 1 || 2 * SPARE > DEPTH) begin : g_bad_spare
      $error("dual_thread_sched_q: SPARE must leave each thread room");
   end
   if (WAKE_N < 1 || WAKE_N > MAX_WAKE) begin : g_bad_wake
      $error("dual_thread_sched_q: WAKE_N out of range");
   end
   if (TAG_W < 2) begin : g_bad_tag
      $error("dual_thread_sched_q: TAG_W too small");
   end

   logic [DEPTH-1:0]            s_vld, s_tid, s_rdy, s_kill, alloc, free_oh, req, gnt;
   logic [DEPTH-1:0][TAG_W-1:0] s_dst;
   logic [1:0][CNT_W-1:0]       occ;
   logic [CNT_W:0]              total;
   logic                        full, found;
   logic [1:0]                  want;
   logic                        wsel;

   // per-thread occupancy
   always_comb begin
      occ = '0;
      for (int i = 0; i < int'(DEPTH); i++)
         if (s_vld[i]) occ[s_tid[i]] = occ[s_tid[i]] + CNT_W'(1);
   end
   assign total = {1'b0, occ[0]} + {1'b0, occ[1]};
   assign full  = (total == FULL_V);

   // insertion eligibility and turn-taking
   for (genvar t = 0; t < int'(THREADS); t++) begin : g_want
      assign want[t] = ins_valid[t] & (occ[t] < CAP_V) & ~full
                       & ~(flush & (flush_tid == t[0]));
   end

   dtsq_ins_arb u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .want  (want),
      .take  (ins_take)
   );

   // lowest free slot receives the accepted micro-op
   always_comb begin
      free_oh = '0;
      found   = 1'b0;
      for (int i = 0; i < int'(DEPTH); i++)
         if (!s_vld[i] && !found) begin
            free_oh[i] = 1'b1;
            found      = 1'b1;
         end
   end
   assign alloc = (|ins_take) ? free_oh : '0;
   assign wsel  = ins_take[1];

   // entries
   for (genvar i = 0; i < int'(DEPTH); i++) begin : g_slot
      dtsq_slot #(.TAG_W(TAG_W), .WAKE_N(WAKE_N)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (alloc[i]),
         .wr_tid    (wsel),
         .wr_a      (ins_src_a[wsel]),
         .wr_a_rdy  (ins_src_a_rdy[wsel]),
         .wr_b      (ins_src_b[wsel]),
         .wr_b_rdy  (ins_src_b_rdy[wsel]),
         .wr_dst    (ins_dst[wsel]),
         .wk_v      (wake_valid),
         .wk_tag    (wake_tag),
         .kill      (s_kill[i]),
         .vld       (s_vld[i]),
         .tid       (s_tid[i]),
         .dst       (s_dst[i]),
         .ops_ready (s_rdy[i])
      );
      assign req[i]    = s_rdy[i] & exec_avail & ~(flush & (s_tid[i] == flush_tid));
      assign s_kill[i] = gnt[i] | (flush & s_vld[i] & (s_tid[i] == flush_tid));
   end

   // oldest-ready selection, blind to thread ownership
   dtsq_age_pick #(.DEPTH(DEPTH)) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .vld   (s_vld),
      .alloc (alloc),
      .req   (req),
      .gnt   (gnt)
   );

   assign disp_valid = |gnt;
   always_comb begin
      disp_tid = 1'b0;
      disp_dst = '0;
      for (int i = 0; i < int'(DEPTH); i++)
         if (gnt[i]) begin
            disp_tid = disp_tid | s_tid[i];
            disp_dst = disp_dst | s_dst[i];
         end
   end
endmodule

// File: rtl/dtsq_chk.sv
module dtsq_chk #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned SPARE = 2,
   parameter int unsigned CNT_W = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [1:0]            ins_valid,
   input logic [1:0]            ins_take,
   input logic                  exec_avail,
   input logic                  flush,
   input logic                  flush_tid,
   input logic                  disp_valid,
   input logic                  disp_tid,
   input logic [1:0][CNT_W-1:0] occ,
   input logic [CNT_W:0]        total
);
   localparam logic [CNT_W-1:0] CAP_V  = CNT_W'(DEPTH - SPARE);
   localparam logic [CNT_W:0]   FULL_V = (CNT_W + 1)'(DEPTH);

   a_r4_cap_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (occ[0] <= CAP_V) && (occ[1] <= CAP_V));
   a_r4_block_t0: assert property (@(posedge clk) disable iff (!rst_n)
      (occ[0] == CAP_V) |-> !ins_take[0]);
   a_r4_block_t1: assert property (@(posedge clk) disable iff (!rst_n)
      (occ[1] == CAP_V) |-> !ins_take[1]);
   a_r5_total_bound: assert property (@(posedge clk) disable iff (!rst_n)
      total <= FULL_V);
   a_r5_block_full: assert property (@(posedge clk) disable iff (!rst_n)
      (total == FULL_V) |-> (ins_take == 2'b00));
   a_r2_single_take: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ins_take));
   a_r2_turn_to_t1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ins_take) == 2'b01) && ins_valid[1] && (occ[1] < CAP_V)
      && (total < FULL_V) && !(flush && flush_tid) |-> ins_take[1]);
   a_r2_turn_to_t0: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ins_take) == 2'b10) && ins_valid[0] && (occ[0] < CAP_V)
      && (total < FULL_V) && !(flush && !flush_tid) |-> ins_take[0]);
   a_r3_lone_t0: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid == 2'b01) && (occ[0] < CAP_V) && (total < FULL_V)
      && !(flush && !flush_tid) |-> ins_take[0]);
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_avail |-> !disp_valid);
   a_r10_owner_present: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid |-> (occ[disp_tid] != '0));
   a_r9_block_insert: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !ins_take[flush_tid]);
   a_r9_no_disp: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && disp_valid) |-> (disp_tid != flush_tid));
   a_r9_emptied: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (occ[$past(flush_tid)] == '0));
   a_r1_empty_after_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> (total == '0) && !disp_valid);
endmodule

bind dual_thread_sched_q dtsq_chk #(
   .DEPTH (DEPTH),
   .SPARE (SPARE),
   .CNT_W (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ins_valid  (ins_valid),
   .ins_take   (ins_take),
   .exec_avail (exec_avail),
   .flush      (flush),
   .flush_tid  (flush_tid),
   .disp_valid (disp_valid),
   .disp_tid   (disp_tid),
   .occ        (occ),
   .total      (total)
);

// File: tb/sim_dual_thread_sched_q.sv
`timescale 1ns/1ps
module sim_dual_thread_sched_q;
   localparam int DEPTH = 8;
   localparam int SPARE = 2;
   localparam int CAP   = DEPTH - SPARE;
   localparam int TW    = 6;

   logic                clk = 1'b0;
   logic                rst_n;
   logic [1:0]          ins_valid, ins_src_a_rdy, ins_src_b_rdy, ins_take;
   logic [1:0][TW-1:0]  ins_src_a, ins_src_b, ins_dst;
   logic [1:0]          wake_valid;
   logic [1:0][TW-1:0]  wake_tag;
   logic                exec_avail, flush, flush_tid;
   logic                disp_valid, disp_tid;
   logic [TW-1:0]       disp_dst;

   always #2.5 clk = ~clk;

   dual_thread_sched_q #(.DEPTH(DEPTH), .TAG_W(TW), .WAKE_N(2), .SPARE(SPARE)) u0 (
      .clk(clk), .rst_n(rst_n),
      .ins_valid(ins_valid), .ins_src_a(ins_src_a), .ins_src_a_rdy(ins_src_a_rdy),
      .ins_src_b(ins_src_b), .ins_src_b_rdy(ins_src_b_rdy), .ins_dst(ins_dst),
      .ins_take(ins_take), .wake_valid(wake_valid), .wake_tag(wake_tag),
      .exec_avail(exec_avail), .flush(flush), .flush_tid(flush_tid),
      .disp_valid(disp_valid), .disp_tid(disp_tid), .disp_dst(disp_dst));

   int checks = 0, fails = 0;
   bit done = 0;

   // reference model: an unordered set of entries with insertion sequence numbers
   int m_v[16], m_tid[16], m_a[16], m_ar[16], m_b[16], m_br[16], m_dst[16], m_seq[16];
   int seq_ctr = 0, last = 1, dst_ctr = 0;
   // feeder heads
   int h_v[2], h_a[2], h_ar[2], h_b[2], h_br[2], h_dst[2];
   // stimulus knobs
   int fe[2], nrdy = 0, pw = 0, pe = 0, pf = 0;

   task automatic chk(string req, int act, int exp, string what);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic bit hitb(int tag);
      for (int w = 0; w < 2; w++)
         if (wake_valid[w] && int'(wake_tag[w]) == tag) return 1'b1;
      return 1'b0;
   endfunction

   task automatic new_head(int t);
      h_v[t]  = 1;
      h_a[t]  = int'($urandom % 16);
      h_b[t]  = int'($urandom % 16);
      h_ar[t] = nrdy ? 0 : int'($urandom % 2);
      h_br[t] = nrdy ? 0 : int'($urandom % 2);
      h_dst[t] = dst_ctr;
      dst_ctr = (dst_ctr + 1) % 64;
   endtask

   task automatic step();
      int cnt[2], tot, g, best, bseq, ev, exp_take;
      bit el[2];
      string rt, rd;
      @(negedge clk);
      for (int t = 0; t < 2; t++) begin
         ins_valid[t]     = h_v[t][0];
         ins_src_a[t]     = TW'(h_a[t]);
         ins_src_b[t]     = TW'(h_b[t]);
         ins_src_a_rdy[t] = h_ar[t][0];
         ins_src_b_rdy[t] = h_br[t][0];
         ins_dst[t]       = TW'(h_dst[t]);
      end
      for (int w = 0; w < 2; w++) begin
         wake_valid[w] = (int'($urandom % 100) < pw);
         wake_tag[w]   = TW'($urandom % 16);
      end
      exec_avail = (int'($urandom % 100) < pe);
      flush      = (int'($urandom % 100) < pf);
      flush_tid  = 1'($urandom % 2);
      #1;
      // expected insertion
      cnt[0] = 0; cnt[1] = 0;
      for (int i = 0; i < 16; i++) if (m_v[i] != 0) cnt[m_tid[i]]++;
      tot = cnt[0] + cnt[1];
      for (int t = 0; t < 2; t++)
         el[t] = (h_v[t] != 0) && cnt[t] < CAP && tot < DEPTH && !(flush && int'(flush_tid) == t);
      rt = "R3";
      for (int t = 0; t < 2; t++)
         if (h_v[t] != 0 && !el[t]) begin
            if (flush && int'(flush_tid) == t) rt = "R9";
            else if (tot >= DEPTH)             rt = "R5";
            else                               rt = "R4";
         end
      if (el[0] && el[1]) begin g = (last == 0) ? 1 : 0; rt = "R2"; end
      else if (el[0]) g = 0;
      else if (el[1]) g = 1;
      else g = -1;
      exp_take = (g < 0) ? 0 : (1 << g);
      chk(rt, int'(ins_take), exp_take, "ins_take");
      // expected dispatch
      best = -1; bseq = 0;
      if (exec_avail)
         for (int i = 0; i < 16; i++)
            if (m_v[i] != 0 && !(flush && int'(flush_tid) == m_tid[i])
                && (m_ar[i] != 0 || hitb(m_a[i])) && (m_br[i] != 0 || hitb(m_b[i]))
                && (best < 0 || m_seq[i] < bseq)) begin
               best = i; bseq = m_seq[i];
            end
      if (!exec_avail)                                    rd = "R6";
      else if (flush)                                     rd = "R9";
      else if (best >= 0 && (m_ar[best] == 0 || m_br[best] == 0)) rd = "R8";
      else                                                rd = "R7";
      ev = (best >= 0) ? 1 : 0;
      chk(rd, int'(disp_valid), ev, "disp_valid");
      if (ev == 1 && disp_valid) begin
         chk("R10", int'(disp_tid), m_tid[best], "disp_tid");
         chk("R10", int'(disp_dst), m_dst[best], "disp_dst");
      end
      // model update for the coming edge
      for (int i = 0; i < 16; i++)
         if (m_v[i] != 0) begin
            if (i == best) m_v[i] = 0;
            else if (flush && int'(flush_tid) == m_tid[i]) m_v[i] = 0;
            else begin
               if (hitb(m_a[i])) m_ar[i] = 1;
               if (hitb(m_b[i])) m_br[i] = 1;
            end
         end
      if (g >= 0) begin
         for (int i = 0; i < 16; i++)
            if (m_v[i] == 0) begin
               m_v[i] = 1; m_tid[i] = g; m_a[i] = h_a[g]; m_b[i] = h_b[g];
               m_ar[i] = (h_ar[g] != 0 || hitb(h_a[g])) ? 1 : 0;
               m_br[i] = (h_br[g] != 0 || hitb(h_b[g])) ? 1 : 0;
               m_dst[i] = h_dst[g]; m_seq[i] = seq_ctr++;
               break;
            end
         last = g;
         h_v[g] = 0;
      end
      for (int t = 0; t < 2; t++) begin
         if (fe[t] == 0) h_v[t] = 0;
         else if (h_v[t] == 0 && int'($urandom % 100) < 80) new_head(t);
      end
   endtask

   task automatic run(int n);
      for (int k = 0; k < n; k++) step();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) m_v[i] = 0;
      for (int t = 0; t < 2; t++) begin h_v[t] = 0; fe[t] = 0; end
      rst_n = 1'b0;
      ins_valid = '0; ins_src_a = '0; ins_src_b = '0; ins_dst = '0;
      ins_src_a_rdy = '0; ins_src_b_rdy = '0;
      wake_valid = '0; wake_tag = '0; exec_avail = 1'b0; flush = 1'b0; flush_tid = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      exec_avail = 1'b1;
      #1;
      // R1: empty queue after reset
      chk("R1", int'(disp_valid), 0, "disp_valid after reset");
      chk("R1", int'(ins_take), 0, "ins_take idle after reset");

      // R4: thread 0 alone, operands held not ready, no dispatch
      fe[0] = 1; fe[1] = 0; nrdy = 1; pw = 0; pe = 0; pf = 0;
      new_head(0);
      run(14);
      // R5: thread 1 joins and the queue fills
      fe[1] = 1;
      run(10);
      // R7 R8: drain through wakeups
      fe[0] = 0; fe[1] = 0; nrdy = 0; pw = 60; pe = 100;
      run(60);
      // R2: both feeders, no dispatch, contested insertion
      fe[0] = 1; fe[1] = 1; nrdy = 1; pw = 0; pe = 0;
      run(12);
      // R6 R7 R8 R9: mixed traffic
      nrdy = 0; pw = 40; pe = 70; pf = 3;
      run(4000);
      // R3: single feeder with fast drain
      fe[0] = 0; pw = 50; pe = 100; pf = 0;
      run(500);
      // R9: frequent flushes
      fe[0] = 1; pf = 20; pe = 60;
      run(600);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule